// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands one step per clock, using radix-2 Booth recoding. A single-cycle start pulse, given while the block is idle, captures the multiplicand and the multiplier. The block then runs one Booth step per clock for as many steps as the operand has bits. In each step it looks at the lowest bit of the working register together with a one-bit extension. Depending on that pair it subtracts the multiplicand from the upper half, adds it, or leaves the register alone. It then shifts the whole working register right by one place and keeps the sign.

The working register is twice the operand width. The multiplier sits in its lower half and the running partial product in its upper half. When the last step is done, the register holds the signed product. A one-cycle done flag marks completion. The product stays on the output until the next accepted start. A start that arrives during a run is ignored.

Top module: `booth_mul`

## Requirements
- R1: After reset, busy is 0, done is 0 and product is 0.
- R2: A start sampled high while busy is 0 captures both operands, and busy is 1 from the next cycle onward.
- R3: done goes high exactly 8 clock edges after the edge that accepted start, together with busy falling, and product then equals the signed 16-bit product of the captured operands.
- R4: Booth recoding works on the pair (low register bit, extension bit): 10 subtracts the multiplicand from the upper half, 01 adds it, and 00 and 11 leave the register unchanged. For example, a multiplicand of -7 (0xF9) times a multiplier of 3 gives 0xFFEB.
- R5: The add and subtract use a sign-extended 9-bit upper half, and the shift is arithmetic. Operand values of -128 (0x80) in either position or in both give correct products, for example -128 times -128 gives 0x4000 and -128 times 127 gives 0xC080.
- R6: done is high for exactly one cycle per multiplication and is never high while busy is high.
- R7: While idle, product holds its value until the next accepted start, whatever the operand inputs do.
- R8: A start pulse while busy is high is ignored: the run in progress finishes at its original time with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | 8 | Signed multiplicand |
| mplier | input | 8 | Signed multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion flag |
| product | output | 16 | Signed product, held while idle |

## Verification
The in-module assertions check on every cycle that done lasts one cycle and never coincides with busy. They also check that an accepted start always raises busy, that a start during a run does not end it early, and that the product does not move while the block is idle with no start. Only the bench's scenarios can show that the arithmetic is right. The bench compares each result against an integer reference product and covers the -128 extremes, the sign combinations, back-to-back starts and a start injected mid-run.

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2*W-1:0] acc;
  logic           qm1;
  logic [W-1:0]   mc;
  logic [CW-1:0]  cnt;

  logic [W:0] hi_ext, mc_ext, sum;
  assign hi_ext = {acc[2*W-1], acc[2*W-1:W]};
  assign mc_ext = {mc[W-1], mc};

  always_comb begin
    case ({acc[0], qm1})
      2'b10:   sum = hi_ext - mc_ext;
      2'b01:   sum = hi_ext + mc_ext;
      default: sum = hi_ext;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      qm1  <= 1'b0;
      mc   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= {sum, acc[W-1:1]};
        qm1 <= acc[0];
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        acc  <= {{W{1'b0}}, mplier};
        qm1  <= 1'b0;
        cnt  <= '0;
        mc   <= mcand;
        busy <= 1'b1;
      end
    end
  end

  assign product = acc;

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> (busy && !done));
endmodule

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [15:0] product;

  int checks = 0, failures = 0;

  booth_mul #(.W(8)) dut (.clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product));

  always #10 clk = ~clk;

  // behavioural reference: step count and integer product
  logic m_busy = 1'b0, m_done = 1'b0;
  int m_steps = 0;
  logic [15:0] m_pend = '0, m_prod = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_steps <= 0; m_prod <= '0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        m_steps <= m_steps + 1;
        if (m_steps + 1 == 8) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_prod <= m_pend;
        end
      end else if (start) begin
        m_busy <= 1'b1; m_steps <= 0;
        m_pend <= 16'($signed(mcand) * $signed(mplier));
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(busy === m_busy, "R2/R8 busy", busy, m_busy);
    check(done === m_done, "R3/R6 done", done, m_done);
    if (!m_busy) check(product === m_prod, "R3/R7 product", product, m_prod);
  end

  task automatic mul(input int a, input int b);
    @(negedge clk);
    mcand = 8'(a); mplier = 8'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check(done === 1'b1, "R3 done timing", done, 1);
    check($signed(product) === 16'(a * b), "R4/R5 result", product, 16'(a * b));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && product === 16'h0, "R1 reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 directed case
    mul(-7, 3);
    check(product === 16'hFFEB, "R4 -7x3", product, 16'hFFEB);
    mul(3, -7);
    mul(0, -55);
    mul(127, 127);
    // R5 extremes
    mul(-128, -128);
    check(product === 16'h4000, "R5 -128x-128", product, 16'h4000);
    mul(-128, 127);
    check(product === 16'hC080, "R5 -128x127", product, 16'hC080);
    mul(127, -128);
    mul(-1, -1);
    mul(-128, 1);
    for (int i = 0; i < 40; i++) mul(((i * 37 + 11) % 256) - 128, ((i * 91 + 5) % 256) - 128);
    // R7 hold while idle with moving inputs
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mcand = 8'(i * 29); mplier = 8'(i * 53);
    end
    check($signed(product) === 16'(((39 * 37 + 11) % 256 - 128) * ((39 * 91 + 5) % 256 - 128)),
          "R7 hold", product, 0);
    // R8 start during a run is ignored
    @(negedge clk);
    mcand = 8'(-5); mplier = 8'(9); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    mcand = 8'(100); mplier = 8'(100); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(done === 1'b1, "R8 original finish time", done, 1);
    check(product === 16'hFFD3, "R8 original operands", product, 16'hFFD3);
    // back-to-back start on the done cycle
    mul(-100, 50);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule